// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps the coherence state of every line of a small write-back cache that sits on a shared snooping bus. Each line holds one of three states. Invalid means the cache has no copy. Shared means it holds a read-only copy that other caches may hold too. Modified means it holds the only valid copy, and that copy is writable and newer than memory. The processor presents one request at a time: a load, a store or an evict, together with a line index. The block either completes the request locally in the same cycle and raises the hit flag, or it issues one bus message and holds the stall flag high. The message is a read, a read-for-ownership, an invalidate or a write-back. After a fixed reply latency the line takes its new state. The processor keeps its request applied, and the same request then completes as a hit.

At the same time the block watches the commands that peer caches put on the bus. When it owns a line that a peer reads, or reads for ownership, it raises the reply flag to supply the data. It then drops its copy to Shared or to Invalid. An invalidate or read-for-ownership from a peer removes a Shared copy. A peer that invalidates a line while this cache waits to upgrade that same line forces the pending store to restart as a read-for-ownership.

The controller FSM uses the states IDLE, WAIT_RD, WAIT_RDX, WAIT_INV, WAIT_WB and REISSUE:
- IDLE moves to WAIT_RD, WAIT_RDX, WAIT_INV or WAIT_WB when a request needs the bus.
- Each WAIT state counts the reply latency and then returns to IDLE.
- WAIT_INV moves to REISSUE when a peer kills the pending line.
- REISSUE moves to WAIT_RDX.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: Reset places every line in Invalid. The state codes are Invalid=00, Shared=01 and Modified=10, and the code 11 never appears. `line_state` shows the stored state of the line addressed by `cpu_idx`. After reset the stall, bus command and reply outputs are 0.
- R2: Operation codes: load=00, store=01, evict=10. A load to a Shared or Modified line raises `cpu_hit` in the same cycle, issues no bus command and leaves the state unchanged. A load to an Invalid line issues the read command (`bus_cmd`=001) and the line ends in Shared.
- R3: A store to an Invalid line issues the read-for-ownership command (`bus_cmd`=010), and the line ends in Modified.
- R4: A store to a Shared line issues the invalidate command (`bus_cmd`=011) with no refetch, and the line ends in Modified. A store to a Modified line hits with no bus command. Whenever a store hits, the line is Modified.
- R5: An evict of a Shared line hits at once and leaves the line Invalid with no bus command. An evict of a Modified line issues the write-back command (`bus_cmd`=100), and the line ends in Invalid. An evict of an Invalid line hits and has no effect.
- R6: Snoop codes: none=00, read=01, read-for-ownership=10, invalidate=11. A snooped read to a Modified line raises `snp_reply` in that cycle and leaves the line Shared. A snooped read leaves Shared and Invalid lines unchanged and raises no reply.
- R7: A snooped read-for-ownership to a Modified line raises `snp_reply` and leaves the line Invalid. A snooped read-for-ownership or invalidate to a Shared line leaves it Invalid with no reply.
- R8: A request that needs the bus drives its command and index on `bus_cmd`/`bus_idx` for exactly one cycle, in the cycle it is first presented. `cpu_stall` is high in that cycle and for the REPLY_LAT cycles that follow. The held request hits in the next cycle. `cpu_hit` and `cpu_stall` are never high together.
- R9: A snooped invalidate or read-for-ownership to a line that is waiting for its own invalidate upgrade leaves that line Invalid. In the next cycle the block issues the read-for-ownership command for that line. The store then completes REPLY_LAT cycles later with the line Modified. A snoop to another line does not disturb the upgrade.
- R10: When a snoop and a processor request address the same line in the same cycle, the reply is decided from the state before the snoop. The processor request is decided from the state after the snoop.
- R11: A request or snoop changes only the line it addresses. All other lines keep their states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request present; held until `cpu_hit` |
| cpu_op | input | 2 | Operation: 00 load, 01 store, 10 evict |
| cpu_idx | input | IDX_W | Line addressed by the processor |
| cpu_hit | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request waits on a bus transaction |
| line_state | output | 2 | Stored state of line `cpu_idx` |
| bus_cmd | output | 3 | Issued message: 000 none, 001 read, 010 read-for-ownership, 011 invalidate, 100 write-back |
| bus_idx | output | IDX_W | Line of the issued message |
| snp_cmd | input | 2 | Peer command seen on the bus: 00 none, 01 read, 10 read-for-ownership, 11 invalidate |
| snp_idx | input | IDX_W | Line of the peer command |
| snp_reply | output | 1 | This cache supplies the data for the snooped line |

## Verification
The bench sweeps every line through every state and every operation and snoop, and compares each result with a table of expected results. A design that skipped the silent evict of a Shared line would emit a spurious bus message. A design that did not supply data would lose Modified data on a peer read. A design that let an invalidate upgrade finish after a peer killed the line would end in Modified with stale data, and the bench looks for the read-for-ownership in the cycle after the kill. The same-cycle snoop cases catch a design that decides the processor request from the pre-snoop state: such a design would hit a load on a line a peer has just claimed, or write a line it no longer owns.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'b00,
        LN_S = 2'b01,
        LN_M = 2'b10
    } line_st_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_EVICT = 2'b10
    } cpu_op_e;

    typedef enum logic [1:0] {
        SNP_NONE = 2'b00,
        SNP_RD   = 2'b01,
        SNP_RDX  = 2'b10,
        SNP_INV  = 2'b11
    } snp_cmd_e;

    typedef enum logic [2:0] {
        BUS_NONE = 3'b000,
        BUS_RD   = 3'b001,
        BUS_RDX  = 3'b010,
        BUS_INV  = 3'b011,
        BUS_WB   = 3'b100
    } bus_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE,
        F_WAIT_RD,
        F_WAIT_RDX,
        F_WAIT_INV,
        F_WAIT_WB,
        F_REISSUE
    } fsm_e;

    // Line state after a peer command has been observed.
    function automatic logic [1:0] snoop_next(input logic [1:0] cur, input logic [1:0] cmd);
        logic [1:0] res;
        res = cur;
        case (cmd)
            SNP_RD:           if (cur == LN_M) res = LN_S;
            SNP_RDX, SNP_INV: res = LN_I;
            default:          res = cur;
        endcase
        return res;
    endfunction

    // This cache owns the data a peer is asking for.
    function automatic logic snoop_reply(input logic [1:0] cur, input logic [1:0] cmd);
        return (cur == LN_M) && ((cmd == SNP_RD) || (cmd == SNP_RDX));
    endfunction

endpackage

// File: rtl/msi_line_array.sv
`timescale 1ns/1ps
module msi_line_array
    import msi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 snp_cmd,
    input  logic [IDX_W-1:0]           snp_idx,
    input  logic                       upd_en,
    input  logic [IDX_W-1:0]           upd_idx,
    input  logic [1:0]                 upd_state,
    output logic [NUM_LINES-1:0][1:0]  lines_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [1:0] st_q;
        logic [1:0] st_n;

        // Snoop first, then the controller's own update for this line.
        always_comb begin
            st_n = st_q;
            if ((snp_cmd != SNP_NONE) && (snp_idx == IDX_W'(g)))
                st_n = snoop_next(st_q, snp_cmd);
            if (upd_en && (upd_idx == IDX_W'(g)))
                st_n = upd_state;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= LN_I;
            else        st_q <= st_n;
        end

        assign lines_o[g] = st_q;
    end

endmodule

// File: rtl/msi_req_fsm.sv
`timescale 1ns/1ps
module msi_req_fsm
    import msi_pkg::*;
#(
    parameter int  IDX_W     = 2,
    parameter int  REPLY_LAT = 3,
    localparam int CNT_W     = $clog2(REPLY_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [1:0]       eff_state,
    input  logic             kill_pend,
    output logic [IDX_W-1:0] pend_idx,
    output logic [2:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    output logic             cpu_hit,
    output logic             cpu_stall,
    output logic             upd_en,
    output logic [IDX_W-1:0] upd_idx,
    output logic [1:0]       upd_state
);

    localparam logic [CNT_W-1:0] LAT_M1 = CNT_W'(REPLY_LAT - 1);

    fsm_e             fsm_q, fsm_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [IDX_W-1:0] pend_q, pend_n;

    logic     local_ok;
    logic     evict_clr;
    bus_cmd_e want;
    logic     cnt_done;

    assign cnt_done = (cnt_q == '0);
    assign pend_idx = pend_q;

    // Decide what the presented request needs, from the post-snoop state.
    always_comb begin
        local_ok  = 1'b0;
        evict_clr = 1'b0;
        want      = BUS_NONE;
        case (req_op)
            OP_LOAD: begin
                if (eff_state == LN_I) want = BUS_RD;
                else                   local_ok = 1'b1;
            end
            OP_STORE: begin
                if (eff_state == LN_I)      want = BUS_RDX;
                else if (eff_state == LN_S) want = BUS_INV;
                else                        local_ok = 1'b1;
            end
            OP_EVICT: begin
                if (eff_state == LN_M) want = BUS_WB;
                else begin
                    local_ok  = 1'b1;
                    evict_clr = (eff_state == LN_S);
                end
            end
            default: local_ok = 1'b1;
        endcase
    end

    // Next state.
    always_comb begin
        fsm_n  = fsm_q;
        cnt_n  = cnt_q;
        pend_n = pend_q;
        unique case (fsm_q)
            F_IDLE: begin
                if (req_valid && !local_ok) begin
                    pend_n = req_idx;
                    cnt_n  = LAT_M1;
                    case (want)
                        BUS_RD:  fsm_n = F_WAIT_RD;
                        BUS_RDX: fsm_n = F_WAIT_RDX;
                        BUS_INV: fsm_n = F_WAIT_INV;
                        BUS_WB:  fsm_n = F_WAIT_WB;
                        default: fsm_n = F_IDLE;
                    endcase
                end
            end
            F_WAIT_RD, F_WAIT_RDX, F_WAIT_WB: begin
                if (cnt_done) fsm_n = F_IDLE;
                else          cnt_n = cnt_q - 1'b1;
            end
            F_WAIT_INV: begin
                if (kill_pend)     fsm_n = F_REISSUE;
                else if (cnt_done) fsm_n = F_IDLE;
                else               cnt_n = cnt_q - 1'b1;
            end
            F_REISSUE: begin
                fsm_n = F_WAIT_RDX;
                cnt_n = LAT_M1;
            end
            default: fsm_n = F_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q  <= F_IDLE;
            cnt_q  <= '0;
            pend_q <= '0;
        end else begin
            fsm_q  <= fsm_n;
            cnt_q  <= cnt_n;
            pend_q <= pend_n;
        end
    end

    // Outputs.
    always_comb begin
        bus_cmd   = BUS_NONE;
        bus_idx   = pend_q;
        cpu_hit   = 1'b0;
        cpu_stall = 1'b1;
        upd_en    = 1'b0;
        upd_idx   = pend_q;
        upd_state = LN_I;
        unique case (fsm_q)
            F_IDLE: begin
                cpu_hit   = req_valid && local_ok;
                cpu_stall = req_valid && !local_ok;
                bus_cmd   = req_valid ? want : BUS_NONE;
                bus_idx   = req_idx;
                upd_en    = req_valid && evict_clr;
                upd_idx   = req_idx;
                upd_state = LN_I;
            end
            F_WAIT_RD: begin
                upd_en    = cnt_done;
                upd_state = LN_S;
            end
            F_WAIT_RDX: begin
                upd_en    = cnt_done;
                upd_state = LN_M;
            end
            F_WAIT_INV: begin
                upd_en    = cnt_done && !kill_pend;
                upd_state = LN_M;
            end
            F_WAIT_WB: begin
                upd_en    = cnt_done;
                upd_state = LN_I;
            end
            F_REISSUE: begin
                bus_cmd = BUS_RDX;
            end
            default: cpu_stall = 1'b0;
        endcase
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
`timescale 1ns/1ps
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int  NUM_LINES = 4,
    parameter int  REPLY_LAT = 3,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_hit,
    output logic             cpu_stall,
    output logic [1:0]       line_state,
    output logic [2:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    input  logic [1:0]       snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_reply
);

    logic [NUM_LINES-1:0][1:0] lines;
    logic [1:0]                req_cur;
    logic [1:0]                snp_cur;
    logic [1:0]                eff_state;
    logic [IDX_W-1:0]          pend_idx;
    logic                      kill_pend;
    logic                      upd_en;
    logic [IDX_W-1:0]          upd_idx;
    logic [1:0]                upd_state;

    assign req_cur    = lines[cpu_idx];
    assign snp_cur    = lines[snp_idx];
    assign line_state = req_cur;

    // A snoop in the same cycle is ordered ahead of the processor request.
    assign eff_state = ((snp_cmd != SNP_NONE) && (snp_idx == cpu_idx))
                       ? snoop_next(req_cur, snp_cmd) : req_cur;
    assign snp_reply = snoop_reply(snp_cur, snp_cmd);
    assign kill_pend = ((snp_cmd == SNP_RDX) || (snp_cmd == SNP_INV)) && (snp_idx == pend_idx);

    msi_line_array #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_cmd   (snp_cmd),
        .snp_idx   (snp_idx),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .upd_state (upd_state),
        .lines_o   (lines)
    );

    msi_req_fsm #(
        .IDX_W     (IDX_W),
        .REPLY_LAT (REPLY_LAT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (cpu_req),
        .req_op    (cpu_op),
        .req_idx   (cpu_idx),
        .eff_state (eff_state),
        .kill_pend (kill_pend),
        .pend_idx  (pend_idx),
        .bus_cmd   (bus_cmd),
        .bus_idx   (bus_idx),
        .cpu_hit   (cpu_hit),
        .cpu_stall (cpu_stall),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .upd_state (upd_state)
    );

endmodule

// File: rtl/msi_snoop_ctrl_checker.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_checker
    import msi_pkg::*;
#(
    parameter int  NUM_LINES = 4,
    parameter int  REPLY_LAT = 3,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [1:0]                cpu_op,
    input logic                      cpu_hit,
    input logic                      cpu_stall,
    input logic [1:0]                line_state,
    input logic [2:0]                bus_cmd,
    input logic [IDX_W-1:0]          bus_idx,
    input logic [1:0]                snp_cmd,
    input logic [IDX_W-1:0]          snp_idx,
    input logic                      snp_reply,
    input logic [NUM_LINES-1:0][1:0] lines
);

    // Window tracker for an outstanding invalidate upgrade.
    int               upg_cnt;
    logic [IDX_W-1:0] upg_idx;
    logic             kill_seen;

    assign kill_seen = (upg_cnt != 0) && ((snp_cmd == SNP_RDX) || (snp_cmd == SNP_INV))
                       && (snp_idx == upg_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upg_cnt <= 0;
            upg_idx <= '0;
        end else if (bus_cmd == BUS_INV) begin
            upg_cnt <= REPLY_LAT;
            upg_idx <= bus_idx;
        end else if (kill_seen) begin
            upg_cnt <= 0;
        end else if (upg_cnt != 0) begin
            upg_cnt <= upg_cnt - 1;
        end
    end

    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        line_state != 2'b11);

    assert_hit_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_hit && cpu_stall));

    assert_cmd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != BUS_NONE) |=> (bus_cmd == BUS_NONE));

    assert_store_owns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hit && (cpu_op == OP_STORE)) |-> (line_state == LN_M));

    assert_reply_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_reply |=> (lines[$past(snp_idx)] != LN_M));

    assert_reissue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_seen |=> ((bus_cmd == BUS_RDX) && (bus_idx == $past(upg_idx))));

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_checker #(
    .NUM_LINES (NUM_LINES),
    .REPLY_LAT (REPLY_LAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_op     (cpu_op),
    .cpu_hit    (cpu_hit),
    .cpu_stall  (cpu_stall),
    .line_state (line_state),
    .bus_cmd    (bus_cmd),
    .bus_idx    (bus_idx),
    .snp_cmd    (snp_cmd),
    .snp_idx    (snp_idx),
    .snp_reply  (snp_reply),
    .lines      (lines)
);

// File: tb/msi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_bench;

    localparam int NL  = 4;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0;
    logic [1:0] cpu_op = 2'b00;
    logic [1:0] cpu_idx = 2'b00;
    logic       cpu_hit, cpu_stall;
    logic [1:0] line_state;
    logic [2:0] bus_cmd;
    logic [1:0] bus_idx;
    logic [1:0] snp_cmd = 2'b00;
    logic [1:0] snp_idx = 2'b00;
    logic       snp_reply;

    int checks = 0;
    int errors = 0;
    int model [NL];

    always #2.5 clk = ~clk;

    msi_snoop_ctrl #(.NUM_LINES(NL), .REPLY_LAT(LAT)) u_msi_snoop_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
        .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .line_state(line_state),
        .bus_cmd(bus_cmd), .bus_idx(bus_idx), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
        .snp_reply(snp_reply)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected bus command for (state, op): 0 none, 1 rd, 2 rdx, 3 inv, 4 wb.
    function automatic int exp_bus(input int st, input int op);
        if (op == 0) return (st == 0) ? 1 : 0;
        if (op == 1) return (st == 0) ? 2 : ((st == 1) ? 3 : 0);
        return (st == 2) ? 4 : 0;
    endfunction

    function automatic int exp_next(input int st, input int op);
        if (op == 0) return (st == 0) ? 1 : st;
        if (op == 1) return 2;
        return 0;
    endfunction

    function automatic string op_tag(input int st, input int op);
        if (op == 0) return "R2";
        if (op == 1) return (st == 0) ? "R3" : "R4";
        return "R5";
    endfunction

    function automatic int snp_next(input int st, input int cmd);
        if (cmd == 1) return (st == 2) ? 1 : st;
        return 0;
    endfunction

    task automatic check_lines(input int target, input string tag);
        for (int i = 0; i < NL; i++) begin
            cpu_idx = 2'(i);
            #0.1;
            chk((i == target) ? tag : "R11 other line", int'(line_state), model[i]);
        end
    endtask

    // Present a request and follow it until it hits.
    task automatic run_op(input int op, input int idx);
        int st, eb;
        string tag;
        st  = model[idx];
        eb  = exp_bus(st, op);
        tag = op_tag(st, op);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'(op); cpu_idx = 2'(idx);
        #1;
        if (eb == 0) begin
            chk({tag, " hit"}, int'(cpu_hit), 1);
            chk({tag, " no bus"}, int'(bus_cmd), 0);
        end else begin
            chk({tag, " bus cmd"}, int'(bus_cmd), eb);
            chk({"R8 bus idx"}, int'(bus_idx), idx);
            chk({"R8 stall issue"}, int'(cpu_stall), 1);
            for (int k = 1; k <= LAT; k++) begin
                @(negedge clk); #1;
                chk("R8 stall wait", int'(cpu_stall), 1);
                chk("R8 single cmd", int'(bus_cmd), 0);
            end
            @(negedge clk); #1;
            chk("R8 hit after wait", int'(cpu_hit), 1);
            chk("R8 no stall at hit", int'(cpu_stall), 0);
        end
        @(negedge clk);
        cpu_req = 1'b0;
        model[idx] = exp_next(st, op);
    endtask

    task automatic bring(input int idx, input int st);
        if (st == 1) run_op(0, idx);
        if (st == 2) run_op(1, idx);
    endtask

    task automatic clear(input int idx);
        if (model[idx] != 0) run_op(2, idx);
    endtask

    task automatic snoop_one(input int idx, input int cmd);
        int st;
        st = model[idx];
        @(negedge clk);
        snp_cmd = 2'(cmd); snp_idx = 2'(idx);
        #1;
        chk((cmd == 1) ? "R6 reply" : "R7 reply", int'(snp_reply),
            ((st == 2) && (cmd != 3)) ? 1 : 0);
        @(negedge clk);
        snp_cmd = 2'b00;
        model[idx] = snp_next(st, cmd);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        errors++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < NL; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 stall", int'(cpu_stall), 0);
        chk("R1 bus", int'(bus_cmd), 0);
        chk("R1 reply", int'(snp_reply), 0);
        check_lines(0, "R1 reset");

        // Every line, every state, every operation.
        for (int idx = 0; idx < NL; idx++) begin
            for (int st = 0; st < 3; st++) begin
                for (int op = 0; op < 3; op++) begin
                    bring(idx, st);
                    run_op(op, idx);
                    check_lines(idx, op_tag(st, op));
                    clear(idx);
                end
            end
        end

        // Every line, every state, every snoop command.
        for (int idx = 0; idx < NL; idx++) begin
            for (int st = 0; st < 3; st++) begin
                for (int cmd = 1; cmd < 4; cmd++) begin
                    bring(idx, st);
                    snoop_one(idx, cmd);
                    check_lines(idx, (cmd == 1) ? "R6 state" : "R7 state");
                    clear(idx);
                end
            end
        end

        // R9: peer kills a pending upgrade.
        bring(0, 1);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'd1; cpu_idx = 2'd0;
        #1; chk("R9 upgrade cmd", int'(bus_cmd), 3);
        @(negedge clk);
        snp_cmd = 2'd3; snp_idx = 2'd0;
        #1; chk("R9 wait stall", int'(cpu_stall), 1);
        @(negedge clk);
        snp_cmd = 2'd0;
        #1;
        chk("R9 reissue cmd", int'(bus_cmd), 2);
        chk("R9 reissue idx", int'(bus_idx), 0);
        chk("R9 line killed", int'(line_state), 0);
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk); #1;
            chk("R9 stall", int'(cpu_stall), 1);
        end
        @(negedge clk); #1;
        chk("R9 store hit", int'(cpu_hit), 1);
        @(negedge clk);
        cpu_req = 1'b0;
        model[0] = 2;
        check_lines(0, "R9 final");
        clear(0);

        // R9: snoop to another line does not disturb the upgrade.
        bring(3, 1);
        bring(0, 1);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'd1; cpu_idx = 2'd0;
        #1; chk("R9 upgrade cmd", int'(bus_cmd), 3);
        @(negedge clk);
        snp_cmd = 2'd3; snp_idx = 2'd3;
        @(negedge clk);
        snp_cmd = 2'd0;
        #1; chk("R9 no reissue", int'(bus_cmd), 0);
        for (int k = 2; k <= LAT; k++) @(negedge clk);
        @(negedge clk); #1;
        chk("R9 upgrade hit", int'(cpu_hit), 1);
        @(negedge clk);
        cpu_req = 1'b0;
        model[0] = 2; model[3] = 0;
        check_lines(0, "R9 upgrade done");
        clear(0);

        // R10: load and peer read-for-ownership hit a Modified line together.
        bring(1, 2);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'd0; cpu_idx = 2'd1;
        snp_cmd = 2'd2; snp_idx = 2'd1;
        #1;
        chk("R10 reply from old state", int'(snp_reply), 1);
        chk("R10 load misses", int'(bus_cmd), 1);
        chk("R10 no hit", int'(cpu_hit), 0);
        @(negedge clk);
        snp_cmd = 2'd0;
        #1; chk("R10 line lost", int'(line_state), 0);
        for (int k = 2; k <= LAT; k++) @(negedge clk);
        @(negedge clk); #1;
        chk("R10 load hit", int'(cpu_hit), 1);
        @(negedge clk);
        cpu_req = 1'b0;
        model[1] = 1;
        check_lines(1, "R10 final");
        clear(1);

        // R10: store and peer read hit a Modified line together.
        bring(2, 2);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'd1; cpu_idx = 2'd2;
        snp_cmd = 2'd1; snp_idx = 2'd2;
        #1;
        chk("R10 reply on read", int'(snp_reply), 1);
        chk("R10 store upgrades", int'(bus_cmd), 3);
        @(negedge clk);
        snp_cmd = 2'd0;
        #1; chk("R10 line shared", int'(line_state), 1);
        for (int k = 2; k <= LAT; k++) @(negedge clk);
        @(negedge clk); #1;
        chk("R10 store hit", int'(cpu_hit), 1);
        @(negedge clk);
        cpu_req = 1'b0;
        model[2] = 2;
        check_lines(2, "R10 final");
        clear(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule